// File: doc/BRIEF.md
# H-Bridge Chopper Current Limiter and Short Classifier

This block watches synchronous current-comparator flags from a two-output H-bridge and decides when every power switch must be forced off. For each output it receives a low-side limit flag, a low-side short flag, a high-side short flag and the high-side gate state. Its one control output, `gate_off_o`, asks the gate driver to switch all four transistors off.

Normal overload is handled by a fixed off-time chopper. A low-side limit crossing first opens a blanking window, and during that window limiting is held back. If the short flag of the same output shows up inside the window, the event is a short to supply. If the window closes without it, the event is ordinary limiting and the chopper switches the bridge off for a fixed number of cycles. A high-side short flag that stays up while that high side is on, for a whole filter delay, is a short to ground. A high-side short and a low-side short that arrive close together are reported as a single short across the load.

Any detected short switches the bridge off at once. The bridge then stays off until reset. Exactly one single-cycle fault pulse is reported per reset. All durations are parameters counted in clock cycles. The bridge outputs are indexed 0 and 1, and a fault vector bit n names bridge output n.

Top module: `hb_chop_guard`

## Requirements
- R1: After reset, `gate_off_o` is 0 and all fault outputs are 0.
- R2: When an idle output's `ls_limit_i` bit is sampled high at edge t, no short follows, and the off-timer is idle, `gate_off_o` is 1 after edges t+BLANK_CYC through t+BLANK_CYC+OFF_CYC-1 and 0 again after edge t+BLANK_CYC+OFF_CYC. No fault is reported.
- R3: A short to supply on output n is detected when `ls_short_i[n]` is sampled high at one of edges t+1 to t+BLANK_CYC of that output's blanking window. This replaces the chop for that window. `ls_short_i` sampled while the off-time runs is ignored.
- R4: A short to ground on output n is detected at the edge where `hs_on_i[n] & hs_short_i[n]` has been sampled high at FILT_CYC consecutive edges. A low sample restarts the count. `hs_short_i[n]` has no effect while `hs_on_i[n]` is 0.
- R5: From the edge at which the first short is detected, `gate_off_o` is 1 and stays 1 until reset.
- R6: If a high-side detection and a low-side detection fall at edges no more than PAIR_CYC apart (the same edge included), one pulse on `load_short_o` is given after the edge of the later detection. No ground or supply pulse is given.
- R7: An unpaired detection at edge d gives one single-cycle pulse after edge d+PAIR_CYC. It is on `gnd_short_o[n]` for a high-side detection or on `sup_short_o[n]` for a low-side detection, where bit n is the output. At most one fault pulse occurs per reset.
- R8: While the off-time runs, limit flags are ignored. If a limit flag is held high, a new blanking window opens on the first edge after the off-time, so the bridge stays on for BLANK_CYC+1 cycles between chops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hs_on_i | input | N_OUT | High-side gate of each output is on |
| hs_short_i | input | N_OUT | High-side current above short threshold |
| ls_limit_i | input | N_OUT | Low-side current above limit threshold |
| ls_short_i | input | N_OUT | Low-side current above short threshold |
| gate_off_o | output | 1 | Force all bridge switches off |
| gnd_short_o | output | N_OUT | Single-cycle short-to-ground pulse, per output |
| sup_short_o | output | N_OUT | Single-cycle short-to-supply pulse, per output |
| load_short_o | output | 1 | Single-cycle short-across-load pulse |

## Verification
The assertions assume that all comparator flags are already synchronous to `clk_i`, so every sample is clean. They also assume that reset is the only way out of a latched shutdown. The stimulus changes flags only on falling clock edges. It applies a new reset before each scenario, so each fault sequence starts from the idle state. Detections are placed at exact edge offsets around the blanking, filter and pairing limits, and the bench never holds a short flag into a window it does not mean to test.

// File: rtl/hb_chop_pkg.sv
package hb_chop_pkg;
  typedef enum logic {
    BL_IDLE,
    BL_WATCH
  } blank_st_e;

  typedef enum logic [1:0] {
    RS_IDLE,
    RS_PAIR,
    RS_DONE
  } res_st_e;
endpackage

// File: rtl/hb_hs_filter.sv
module hb_hs_filter #(
  parameter int FILT_CYC = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic short_i,
  output logic det_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          qual;

  assign qual  = on_i & short_i;
  assign det_o = qual && (cnt_q == CW'(FILT_CYC - 1));

  // saturates at FILT_CYC so a held flag detects once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!qual) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(FILT_CYC)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hb_ls_blanker.sv
module hb_ls_blanker
  import hb_chop_pkg::*;
#(
  parameter int BLANK_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic limit_i,
  input  logic short_i,
  output logic det_o,
  output logic chop_o
);
  localparam int CW = $clog2(BLANK_CYC + 1);

  blank_st_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(BLANK_CYC - 1));
  assign det_o  = (st_q == BL_WATCH) && !hold_i && short_i;
  assign chop_o = (st_q == BL_WATCH) && !hold_i && !short_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BL_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        BL_IDLE: begin
          if (limit_i && !hold_i) begin
            st_q  <= BL_WATCH;
            cnt_q <= '0;
          end
        end
        BL_WATCH: begin
          if (hold_i || short_i || last) st_q <= BL_IDLE;
          else                           cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= BL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hb_off_timer.sv
module hb_off_timer #(
  parameter int OFF_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(OFF_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (busy_o)  cnt_q <= cnt_q - 1'b1;
    else if (start_i) cnt_q <= CW'(OFF_CYC);
  end
endmodule

// File: rtl/hb_fault_resolver.sv
module hb_fault_resolver
  import hb_chop_pkg::*;
#(
  parameter int N_OUT    = 2,
  parameter int PAIR_CYC = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_OUT-1:0] hs_det_i,
  input  logic [N_OUT-1:0] ls_det_i,
  output logic             shut_o,
  output logic [N_OUT-1:0] gnd_o,
  output logic [N_OUT-1:0] sup_o,
  output logic             load_o
);
  localparam int CW = $clog2(PAIR_CYC + 1);

  res_st_e          st_q;
  logic [CW-1:0]    cnt_q;
  logic             first_hs_q;
  logic [N_OUT-1:0] who_q;
  logic             any_hs, any_ls, opposite;

  assign any_hs   = |hs_det_i;
  assign any_ls   = |ls_det_i;
  assign opposite = first_hs_q ? any_ls : any_hs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= RS_IDLE;
      cnt_q      <= '0;
      first_hs_q <= 1'b0;
      who_q      <= '0;
      shut_o     <= 1'b0;
      gnd_o      <= '0;
      sup_o      <= '0;
      load_o     <= 1'b0;
    end else begin
      gnd_o  <= '0;
      sup_o  <= '0;
      load_o <= 1'b0;
      unique case (st_q)
        RS_IDLE: begin
          if (any_hs || any_ls) begin
            shut_o <= 1'b1;
            if (any_hs && any_ls) begin
              load_o <= 1'b1;
              st_q   <= RS_DONE;
            end else begin
              st_q       <= RS_PAIR;
              cnt_q      <= '0;
              first_hs_q <= any_hs;
              who_q      <= any_hs ? hs_det_i : ls_det_i;
            end
          end
        end
        RS_PAIR: begin
          if (opposite) begin
            load_o <= 1'b1;
            st_q   <= RS_DONE;
          end else if (cnt_q == CW'(PAIR_CYC - 1)) begin
            if (first_hs_q) gnd_o <= who_q;
            else            sup_o <= who_q;
            st_q <= RS_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hb_chop_guard.sv
module hb_chop_guard #(
  parameter int N_OUT     = 2,
  parameter int FILT_CYC  = 200,
  parameter int BLANK_CYC = 50,
  parameter int OFF_CYC   = 1000,
  parameter int PAIR_CYC  = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_OUT-1:0] hs_on_i,
  input  logic [N_OUT-1:0] hs_short_i,
  input  logic [N_OUT-1:0] ls_limit_i,
  input  logic [N_OUT-1:0] ls_short_i,
  output logic             gate_off_o,
  output logic [N_OUT-1:0] gnd_short_o,
  output logic [N_OUT-1:0] sup_short_o,
  output logic             load_short_o
);
  logic [N_OUT-1:0] hs_det, ls_det, chop_req;
  logic             chop_busy, shut;

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    hb_hs_filter #(.FILT_CYC(FILT_CYC)) u_hs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .on_i    (hs_on_i[g]),
      .short_i (hs_short_i[g]),
      .det_o   (hs_det[g])
    );

    hb_ls_blanker #(.BLANK_CYC(BLANK_CYC)) u_ls (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hold_i  (chop_busy),
      .limit_i (ls_limit_i[g]),
      .short_i (ls_short_i[g]),
      .det_o   (ls_det[g]),
      .chop_o  (chop_req[g])
    );
  end

  hb_off_timer #(.OFF_CYC(OFF_CYC)) u_off (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (|chop_req && !shut),
    .busy_o  (chop_busy)
  );

  hb_fault_resolver #(.N_OUT(N_OUT), .PAIR_CYC(PAIR_CYC)) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hs_det_i (hs_det),
    .ls_det_i (ls_det),
    .shut_o   (shut),
    .gnd_o    (gnd_short_o),
    .sup_o    (sup_short_o),
    .load_o   (load_short_o)
  );

  assign gate_off_o = shut | chop_busy;
endmodule

// File: rtl/hb_chop_guard_chk.sv
module hb_chop_guard_chk #(
  parameter int N_OUT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gate_off_o,
  input logic [N_OUT-1:0] gnd_short_o,
  input logic [N_OUT-1:0] sup_short_o,
  input logic             load_short_o
);
  logic fault_any, reported_q;

  assign fault_any = (|gnd_short_o) | (|sup_short_o) | load_short_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        reported_q <= 1'b0;
    else if (fault_any) reported_q <= 1'b1;
  end

  p_one_kind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({gnd_short_o, sup_short_o, load_short_o}) <= 1);

  p_pulse_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_any |=> !fault_any);

  p_report_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reported_q |-> !fault_any);

  p_fault_gates_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_any |-> gate_off_o);

  p_off_latched_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reported_q |-> gate_off_o);
endmodule

bind hb_chop_guard hb_chop_guard_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .gate_off_o   (gate_off_o),
  .gnd_short_o  (gnd_short_o),
  .sup_short_o  (sup_short_o),
  .load_short_o (load_short_o)
);

// File: tb/hb_chop_guard_tb_top.sv
module hb_chop_guard_tb_top;
  localparam int FILT  = 8;
  localparam int BLANK = 6;
  localparam int OFF   = 20;
  localparam int PAIR  = 10;

  // kind codes: 0 ground short, 1 supply short, 2 across load
  typedef struct {
    int    kind;
    int    idx;
    int    at;
    string req;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] hs_on = '0, hs_short = '0, ls_limit = '0, ls_short = '0;
  logic       gate_off, load_short;
  logic [1:0] gnd_short, sup_short;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_fail = 0;
  ev_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hb_chop_guard #(
    .N_OUT(2), .FILT_CYC(FILT), .BLANK_CYC(BLANK), .OFF_CYC(OFF), .PAIR_CYC(PAIR)
  ) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .hs_on_i      (hs_on),
    .hs_short_i   (hs_short),
    .ls_limit_i   (ls_limit),
    .ls_short_i   (ls_short),
    .gate_off_o   (gate_off),
    .gnd_short_o  (gnd_short),
    .sup_short_o  (sup_short),
    .load_short_o (load_short)
  );

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: pops expected fault items as the design reports them
  always @(negedge clk) begin : mon
    ev_t g, e;
    if (rst_n && (|gnd_short || |sup_short || load_short)) begin
      g.at = cyc;
      if (load_short)     begin g.kind = 2; g.idx = 0; end
      else if (|gnd_short) begin g.kind = 0; g.idx = gnd_short[1] ? 1 : 0; end
      else                begin g.kind = 1; g.idx = sup_short[1] ? 1 : 0; end
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected fault kind", g.kind, -1);
      end else begin
        e = exp_q.pop_front();
        check(g.kind == e.kind, e.req, "fault kind", g.kind, e.kind);
        check(g.idx == e.idx, e.req, "fault output", g.idx, e.idx);
        check(g.at == e.at, e.req, "fault cycle", g.at, e.at);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic expect_ev(int kind, int idx, int at, string req);
    ev_t e;
    e.kind = kind; e.idx = idx; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic chk_gate(int at, bit v, string req);
    wait_to(at);
    check(gate_off == v, req, "gate_off", int'(gate_off), int'(v));
  endtask

  task automatic drain(int at, string req);
    wait_to(at);
    check(exp_q.size() == 0, req, "pending expected faults", exp_q.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    hs_on = '0; hs_short = '0; ls_limit = '0; ls_short = '0;
    exp_q.delete();
    tick(2);
    rst_n = 1'b1;
    tick(1);
    check(gate_off == 1'b0, "R1", "gate_off after reset", int'(gate_off), 0);
    check({gnd_short, sup_short, load_short} == '0, "R1", "faults after reset",
          int'({gnd_short, sup_short, load_short}), 0);
  endtask

  task automatic finish_sim();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 1, 0);
    finish_sim();
  end

  initial begin : driver
    int s, c, d;
    // R2: single chop on output 0
    do_reset();
    s = cyc; ls_limit = 2'b01; tick(1); ls_limit = '0;
    c = s + 1 + BLANK;
    chk_gate(c - 1, 1'b0, "R2");
    chk_gate(c, 1'b1, "R2");
    chk_gate(c + OFF - 1, 1'b1, "R2");
    chk_gate(c + OFF, 1'b0, "R2");
    drain(c + OFF + 5, "R2");

    // R8: held limit on output 1 re-arms after off-time
    do_reset();
    s = cyc; ls_limit = 2'b10;
    c = s + 1 + BLANK;
    chk_gate(c, 1'b1, "R8");
    chk_gate(c + OFF, 1'b0, "R8");
    chk_gate(c + OFF + BLANK, 1'b0, "R8");
    chk_gate(c + OFF + BLANK + 1, 1'b1, "R8");
    ls_limit = '0;
    drain(c + OFF + BLANK + 4, "R8");

    // R3: short to supply at last blanking edge, output 1
    do_reset();
    s = cyc; ls_limit = 2'b10;
    d = s + BLANK + 1;
    expect_ev(1, 1, d + PAIR, "R3");
    wait_to(s + BLANK); ls_short = 2'b10;
    chk_gate(d - 1, 1'b0, "R3");
    chk_gate(d, 1'b1, "R5");
    chk_gate(d + PAIR + 20, 1'b1, "R5");
    drain(d + PAIR + 21, "R3");

    // R3: short one edge after window is ignored during off-time
    do_reset();
    s = cyc; ls_limit = 2'b01;
    c = s + 1 + BLANK;
    wait_to(s + BLANK + 1); ls_short = 2'b01;
    tick(1); ls_short = '0; ls_limit = '0;
    chk_gate(c + OFF, 1'b0, "R3");
    drain(c + OFF + PAIR + 5, "R3");

    // R4: short to ground on output 0
    do_reset();
    s = cyc; hs_on = 2'b01; hs_short = 2'b01;
    d = s + FILT;
    expect_ev(0, 0, d + PAIR, "R4");
    chk_gate(d - 1, 1'b0, "R4");
    chk_gate(d, 1'b1, "R5");
    drain(d + PAIR + 5, "R4");

    // R4: filter restarts on a low sample
    do_reset();
    s = cyc; hs_on = 2'b01; hs_short = 2'b01;
    wait_to(s + FILT - 1); hs_short = '0;
    tick(1); hs_short = 2'b01;
    d = s + 2 * FILT;
    expect_ev(0, 0, d + PAIR, "R4");
    chk_gate(s + FILT + 1, 1'b0, "R4");
    chk_gate(d - 1, 1'b0, "R4");
    chk_gate(d, 1'b1, "R4");
    drain(d + PAIR + 5, "R4");

    // R4: short flag ignored while that high side is off
    do_reset();
    s = cyc; hs_on = 2'b01; hs_short = 2'b10;
    chk_gate(s + 3 * FILT, 1'b0, "R4");
    hs_on = 2'b00; hs_short = 2'b11;
    chk_gate(s + 6 * FILT, 1'b0, "R4");
    drain(s + 6 * FILT + PAIR + 2, "R4");

    // R6: both sides on the same edge
    do_reset();
    s = cyc; hs_on = 2'b10; hs_short = 2'b10;
    d = s + FILT;
    expect_ev(2, 0, d, "R6");
    wait_to(s + FILT - 3); ls_limit = 2'b10;
    wait_to(s + FILT - 1); ls_short = 2'b10;
    drain(d + PAIR + 5, "R6");

    // R6: low side arrives PAIR edges after high side
    do_reset();
    s = cyc; hs_on = 2'b01; hs_short = 2'b01;
    d = s + FILT;
    expect_ev(2, 0, d + PAIR, "R6");
    wait_to(d + PAIR - 4); ls_limit = 2'b01;
    wait_to(d + PAIR - 1); ls_short = 2'b01;
    drain(d + PAIR + 5, "R6");

    // R6: low side first, high side four edges later
    do_reset();
    s = cyc; hs_on = 2'b01; hs_short = 2'b01;
    wait_to(s + FILT - 6); ls_limit = 2'b10;
    wait_to(s + FILT - 5); ls_short = 2'b10;
    expect_ev(2, 0, s + FILT, "R6");
    drain(s + FILT + PAIR + 5, "R6");

    // R7: low side one edge beyond the pairing window
    do_reset();
    s = cyc; hs_on = 2'b10; hs_short = 2'b10;
    d = s + FILT;
    expect_ev(0, 1, d + PAIR, "R7");
    wait_to(d + PAIR - 3); ls_limit = 2'b01;
    wait_to(d + PAIR); ls_short = 2'b01;
    chk_gate(d + PAIR + 15, 1'b1, "R5");
    drain(d + 2 * PAIR + 10, "R7");

    do_reset();
    finish_sim();
  end
endmodule